// File: doc/BRIEF.md
# Bitstream Window Aligner

This block sits between a compressed-data input buffer and a table-driven variable-length decoder. It receives the packed bitstream as 64-bit words over a valid/ready handshake and keeps two of them staged, an upper word and a lower word. From that pair it presents a 28-bit window that always starts at the current bit pointer. A codeword table downstream can therefore resolve one symbol of any length up to 28 bits in every cycle.

In each cycle the consumer returns how many bits it used. In variable-length mode that is the code length reported by the table. In field mode it is the width of a fixed-length header field, and the block also presents that field right-justified. A separate command moves the pointer forward to the next byte boundary, which is used when searching for start codes. When the pointer runs past the end of the upper word, the lower word is promoted to the upper slot. A fresh word can be taken into the lower slot in that same cycle, so a steady supply keeps the window valid with no bubble. A synchronous flush discards both words and restarts at bit zero of the next word that arrives.

Top module: `bit_window_aligner`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `win_valid` is 0 and `in_ready` is 1. The pointer starts at bit 0 of the first word accepted.
- R2: The stream order puts bit 63 of each accepted word first, and accepted words follow in acceptance order. When `win_valid` is 1, `win[i]` equals stream bit `p+i`, where `p` is the current pointer.
- R3: `win_valid` is 1 exactly when both the upper and the lower word are loaded. While it is 0, `take` and `align` have no effect and the window does not move.
- R4: When `win_valid`=1, `take`=1, `align`=0 and `mode`=0, the pointer advances by `vlc_len`. A value of 0 leaves the pointer in place, and any value above 28 counts as 28.
- R5: When `mode`=1, a take advances by `fld_len`, clamped the same way. At all times `fld_data` holds the first `fld_len` window bits, right-justified, with `win[0]` as the most significant of them and every higher bit 0.
- R6: When an advance carries the pointer past bit 63, the lower word becomes the upper word, and `in_ready` is 1 in that cycle. A word offered then goes straight into the lower slot, so `win_valid` stays 1.
- R7: When `win_valid`=1, `align`=1 moves the pointer to the next multiple of 8 and leaves it in place if it is already aligned. `align` takes priority over `take`.
- R8: `flush`=1 empties both slots and sets the pointer to 0 at the next edge, and `in_ready` is 0 during the flush cycle. The next two words accepted become the upper word and then the lower word.
- R9: While both slots are full and no carry occurs, `in_ready` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| flush | input | 1 | Discard staged words and restart at bit 0 |
| in_valid | input | 1 | Input word offered |
| in_data | input | 64 | Input word, bit 63 first in the stream |
| in_ready | output | 1 | Input word accepted this cycle when in_valid is high |
| win_valid | output | 1 | Window holds a full 28 stream bits |
| win | output | 28 | Stream bits at the pointer, bit 0 first |
| fld_data | output | 28 | First fld_len window bits, right-justified |
| mode | input | 1 | 0: advance by vlc_len, 1: advance by fld_len |
| take | input | 1 | Consume bits this cycle |
| align | input | 1 | Advance the pointer to the next byte boundary |
| vlc_len | input | 5 | Decoded code length |
| fld_len | input | 5 | Fixed field width |

## Verification
On every cycle, the assertions check the following properties. A window that is not consumed stays put. After any take, the surviving window bits have shifted down by exactly the length used. An align always leaves the pointer on a byte boundary. `fld_data` never carries bits above the field width. A flush always empties the window, and a full, idle pair always refuses input.

Other behaviour needs the bench's reference model of the stream. That covers whether the window content matches the true stream position across word boundaries, whether carries and refills happen without a bubble, and whether flushes restart on the right word.

// File: rtl/bit_window_aligner.sv
module bit_window_aligner #(
  parameter int W     = 64,
  parameter int WIN   = 28,
  parameter int LW    = 5,
  parameter int ALIGN = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           flush,
  input  logic           in_valid,
  input  logic [W-1:0]   in_data,
  output logic           in_ready,
  output logic           win_valid,
  output logic [WIN-1:0] win,
  output logic [WIN-1:0] fld_data,
  input  logic           mode,
  input  logic           take,
  input  logic           align,
  input  logic [LW-1:0]  vlc_len,
  input  logic [LW-1:0]  fld_len
);
  localparam int PW = $clog2(W);
  localparam int SW = PW + 1;
  localparam int AB = $clog2(ALIGN);

  logic [W-1:0]   upper_q, lower_q;
  logic           up_v, lo_v;
  logic [PW-1:0]  ptr_q;

  logic [2*W-1:0] shifted;
  logic [WIN-1:0] rev;
  logic [LW-1:0]  vl_c, fl_c, take_len;
  logic [AB-1:0]  pad;
  logic [SW-1:0]  adv_len, sum;
  logic           adv, carry, accept;

  assign shifted = {upper_q, lower_q} << ptr_q;

  for (genvar i = 0; i < WIN; i++) begin : g_win
    assign win[i] = shifted[2*W-1-i];
  end

  assign rev  = shifted[2*W-1 -: WIN];
  assign vl_c = (vlc_len > LW'(WIN)) ? LW'(WIN) : vlc_len;
  assign fl_c = (fld_len > LW'(WIN)) ? LW'(WIN) : fld_len;
  assign fld_data = rev >> ((LW+1)'(WIN) - {1'b0, fl_c});

  assign take_len  = mode ? fl_c : vl_c;
  assign pad       = -ptr_q[AB-1:0];
  assign adv_len   = align ? SW'(pad) : SW'(take_len);
  assign win_valid = up_v && lo_v;
  assign adv       = win_valid && (align || take) && !flush;
  assign sum       = {1'b0, ptr_q} + adv_len;
  assign carry     = adv && sum[PW];
  assign in_ready  = !flush && (!up_v || !lo_v || carry);
  assign accept    = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      upper_q <= '0;
      lower_q <= '0;
      up_v    <= 1'b0;
      lo_v    <= 1'b0;
      ptr_q   <= '0;
    end else begin
      if (adv) ptr_q <= sum[PW-1:0];
      if (carry) begin
        upper_q <= lower_q;
        lo_v    <= accept;
        if (accept) lower_q <= in_data;
      end else if (accept) begin
        if (!up_v) begin
          upper_q <= in_data;
          up_v    <= 1'b1;
        end else begin
          lower_q <= in_data;
          lo_v    <= 1'b1;
        end
      end
    end
  end

  AST_HOLD_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid && !take && !align && !flush |=> win_valid && $stable(win)); // R3
  AST_IDLE_PTR: assert property (@(posedge clk) disable iff (!rst_n)
    !win_valid && !flush |=> $stable(ptr_q)); // R3
  AST_TAKE_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid && take && !align && !flush |=>
    ((win ^ ($past(win) >> $past(take_len))) & ({WIN{1'b1}} >> $past(take_len))) == '0); // R4
  AST_FLD_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (fld_data >> fl_c) == '0); // R5
  AST_ALIGN_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid && align && !flush |=> ptr_q[AB-1:0] == '0); // R7
  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !win_valid); // R8
  AST_FULL_REFUSE: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid && !take && !align |-> !in_ready); // R9
endmodule

// File: tb/bit_window_aligner_tb_top.sv
module bit_window_aligner_tb_top;
  logic        clk = 1'b0;
  logic        rst_n, flush, in_valid, in_ready, win_valid, mode, take, align;
  logic [63:0] in_data;
  logic [27:0] win, fld_data;
  logic [4:0]  vlc_len, fld_len;

  always #4 clk = ~clk;

  bit_window_aligner dut_i (
    .clk(clk), .rst_n(rst_n), .flush(flush), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .win_valid(win_valid), .win(win), .fld_data(fld_data),
    .mode(mode), .take(take), .align(align), .vlc_len(vlc_len), .fld_len(fld_len));

  bit [63:0] words [0:2047];
  int gw, base, cnt, pos, checks, fails;

  function automatic bit sbit(int k);
    return words[(base + k / 64) % 2048][63 - k % 64];
  endfunction

  function automatic int clamp(int v);
    return (v > 28) ? 28 : v;
  endfunction

  task automatic chk(bit ok, string tag, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic step(bit fl, bit al, bit tk, bit md, int vl, int fln, bit iv, string tag);
    int have, len;
    bit ev, er, advance, cy;
    logic [27:0] ew, ef;
    @(negedge clk);
    flush = fl; align = al; take = tk; mode = md;
    vlc_len = 5'(vl); fld_len = 5'(fln); in_valid = iv; in_data = words[gw % 2048];
    #1;
    have    = cnt - pos / 64;
    ev      = have >= 2;
    len     = al ? (8 - pos % 8) % 8 : (md ? clamp(fln) : clamp(vl));
    advance = ev && (al || tk) && !fl;
    cy      = advance && (pos % 64 + len >= 64);
    er      = !fl && (have < 2 || cy);
    chk(win_valid === ev, "R3", "win_valid", 64'(win_valid), 64'(ev));
    chk(in_ready === er, cy ? "R6" : (fl ? "R8" : "R9"), "in_ready", 64'(in_ready), 64'(er));
    if (ev) begin
      ew = '0; ef = '0;
      for (int i = 0; i < 28; i++) ew[i] = sbit(pos + i);
      for (int i = 0; i < clamp(fln); i++) ef[clamp(fln) - 1 - i] = sbit(pos + i);
      chk(win === ew, tag, "win", 64'(win), 64'(ew));
      chk(fld_data === ef, "R5", "fld_data", 64'(fld_data), 64'(ef));
    end
    if (fl) begin
      base = gw; cnt = 0; pos = 0;
    end else begin
      if (advance) pos += len;
      if (iv && er) begin cnt++; gw++; end
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd20240917));
    for (int i = 0; i < 2048; i++) words[i] = {$urandom, $urandom};
    rst_n = 1'b0; flush = 0; in_valid = 0; take = 0; align = 0; mode = 0;
    vlc_len = 0; fld_len = 0; in_data = '0;
    gw = 0; base = 0; cnt = 0; pos = 0; checks = 0; fails = 0;
    repeat (3) @(negedge clk);
    #1;
    chk(win_valid === 1'b0, "R1", "win_valid in reset", 64'(win_valid), 64'd0);
    chk(in_ready === 1'b1, "R1", "in_ready in reset", 64'(in_ready), 64'd1);
    rst_n = 1'b1;
    step(0, 0, 0, 0, 0, 1, 0, "R1");
    step(0, 0, 1, 0, 5, 1, 0, "R3");
    step(0, 1, 0, 0, 0, 1, 0, "R3");
    step(0, 0, 0, 0, 0, 1, 1, "R2");
    step(0, 0, 0, 0, 0, 1, 1, "R2");
    step(0, 0, 0, 0, 0, 1, 1, "R2");
    step(0, 0, 1, 0, 31, 1, 0, "R4");
    step(0, 0, 1, 0, 0, 1, 0, "R4");
    step(0, 0, 1, 0, 3, 28, 0, "R4");
    step(0, 1, 1, 0, 20, 28, 0, "R7");
    step(0, 1, 0, 0, 0, 12, 0, "R7");
    step(0, 0, 1, 1, 0, 1, 0, "R5");
    step(0, 0, 1, 1, 0, 28, 0, "R5");
    for (int i = 0; i < 20; i++) step(0, 0, 1, 0, 28, 7, 1, "R6");
    step(1, 0, 1, 0, 9, 4, 1, "R8");
    step(0, 0, 0, 0, 0, 4, 1, "R8");
    step(0, 0, 0, 0, 0, 4, 1, "R8");
    step(0, 0, 1, 1, 0, 17, 1, "R8");
    for (int n = 0; n < 4000; n++) begin
      step(($urandom % 300) == 0, ($urandom % 12) == 0, ($urandom % 4) != 0,
           $urandom % 2, $urandom % 32, 1 + $urandom % 28, ($urandom % 8) != 0, "R2");
    end
    summary();
    $finish;
  end
endmodule